// File: doc/BRIEF.md
# Lockable GPIO Pad Configuration Bank

This block holds the configuration of a group of general-purpose I/O pads behind a small register interface. Each pad has a three-bit configuration word. One bit picks between the pad's native function and software control. One bit gives the direction, and one bit gives the driven level. When software owns a pad, the pad outputs follow that word. In native mode they follow the native-function inputs.

Two per-pad lock vectors protect this state once boot code has configured the platform. The configuration lock freezes the whole word of a pad. The transmit lock freezes only the driven level. A bank-wide lockdown bit freezes every configuration word at once. Any caller may set a lock, but a lock can only be cleared while the privileged-mode input is high. Releasing the bank-wide lockdown raises a one-cycle interrupt, so privileged code can audit the change. Requests are accepted only when the address carries this bank's port ID: the address is the base address, plus the port ID shifted left by 16, plus a 16-bit register offset. Every accepted request gets a registered response one cycle later.

Top module: `gpl_bank`

## Requirements
- R1: After reset, every configuration word, both lock vectors, the lockdown bit, the error flag and the interrupt are 0. Every pad starts in native mode, so `pad_out_o`/`pad_oe_o` follow `native_out_i`/`native_oe_i`.
- R2: A write to a pad register (offset 0x100 + 4·pad) stores the data bits in the pad's configuration word: bit 0 is the mode (1 = software-controlled), bit 1 is the direction (1 = drive) and bit 2 is the output level. In software mode `pad_out_o` equals bit 2 and `pad_oe_o` equals bit 1. In native mode both follow the native inputs.
- R3: The configuration-lock register at offset 0x010 holds one bit per pad, with bit position equal to the pad index. While a pad's bit is set, writes to that pad's register leave all three fields unchanged.
- R4: The transmit-lock register at offset 0x014 has the same bit layout. While a pad's bit is set and its configuration lock is clear, a write updates mode and direction but leaves the output level unchanged.
- R5: Writing a 1 to a lock bit sets it in any mode. A written 0 clears a lock bit only when `priv_i` is high and is otherwise ignored. Lock bits that have no pad read as 0.
- R6: The control register at offset 0x000 holds the bank-wide lockdown in bit 0, which follows the same set and clear rules as R5. While it is set, writes to every pad register have no effect.
- R7: When the lockdown bit changes from 1 to 0, `smi_o` is high for exactly one cycle, in the first cycle in which the bit reads 0. It is low at all other times.
- R8: A request whose address does not carry the configured port ID above the base address has no effect and returns `rsp_hit_o` = 0 and data 0. Offsets that name no register, including pad registers beyond the pad count, read as 0.
- R9: Control bit 1 is a sticky error flag. It is set by any write that a lock blocked: a locked pad write, a transmit-locked write that would change the level, or an unprivileged attempt to clear a lock. Writing 1 to control bit 1 clears it, unless the same write is itself blocked.
- R10: Each request with `req_valid_i` high produces `rsp_valid_o` in the next cycle. For an accepted read, `rsp_rdata_o` holds the register value at the time of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 1 | Privileged mode; enables lock clearing |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Full address: base + port ID << 16 + offset |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_hit_o | output | 1 | Request matched this bank's port ID |
| rsp_rdata_o | output | 32 | Read data |
| native_out_i | input | NUM_PADS | Native-function output levels |
| native_oe_i | input | NUM_PADS | Native-function output enables |
| pad_out_o | output | NUM_PADS | Level driven to each pad |
| pad_oe_o | output | NUM_PADS | Output enable for each pad |
| smi_o | output | 1 | One-cycle pulse when the lockdown is released |

## Verification
The main function is tried with write and read-back sequences to a single pad under each lock combination: no lock, configuration lock only, transmit lock only, and bank-wide lockdown. Together these separate a full-word freeze from a level-only freeze and show that the lockdown overrides the per-pad state. Lock registers are written with zeros in both privilege modes, which separates a set-only path from a true clear. An all-ones write shows that lock bits beyond the pad count read as zero. Directed sequences time the release interrupt against the cycle in which the lockdown bit changes, check a mismatched port ID and an unmapped pad offset, and switch one pad between native and software mode to check the output selection.

// File: rtl/gpl_pkg.sv
package gpl_pkg;
  localparam logic [15:0] OFF_CTRL     = 16'h0000;
  localparam logic [15:0] OFF_CFG_LOCK = 16'h0010;
  localparam logic [15:0] OFF_TX_LOCK  = 16'h0014;
  localparam logic [15:0] OFF_PAD_BASE = 16'h0100;

  localparam int CTRL_GLOCK = 0;
  localparam int CTRL_ERR   = 1;

  localparam int CFG_W    = 3;
  localparam int FLD_MODE = 0;
  localparam int FLD_DIR  = 1;
  localparam int FLD_OUT  = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CFG_LOCK,
    SEL_TX_LOCK,
    SEL_PAD
  } sel_e;

  // Lock update: a set is always allowed, a clear only in privileged mode.
  function automatic logic [31:0] lock_next(logic [31:0] cur, logic [31:0] wd, logic priv);
    return priv ? wd : (cur | wd);
  endfunction

  // A clear attempt without privilege on any currently set bit.
  function automatic logic lock_clear_denied(logic [31:0] cur, logic [31:0] wd, logic priv);
    return !priv && ((cur & ~wd) != 32'h0);
  endfunction
endpackage

// File: rtl/gpl_addr_dec.sv
module gpl_addr_dec
  import gpl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 40,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [7:0]  PORT_ID  = 8'h00,
  parameter int unsigned NUM_PADS = 24,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              port_hit_o,
  output sel_e              sel_o,
  output logic [IDX_W-1:0]  pad_idx_o
);
  logic [ADDR_W-1:0] rel;
  logic [15:0]       off;
  logic [15:0]       pad_rel;
  logic [13:0]       pad_num;
  logic              in_range;

  always_comb begin
    rel        = addr_i - BASE;
    in_range   = (addr_i >= BASE);
    off        = rel[15:0];
    pad_rel    = off - OFF_PAD_BASE;
    pad_num    = pad_rel[15:2];
    port_hit_o = in_range && (rel[ADDR_W-1:24] == '0) && (rel[23:16] == PORT_ID);
    pad_idx_o  = pad_num[IDX_W-1:0];
    sel_o      = SEL_NONE;
    if (off == OFF_CTRL)          sel_o = SEL_CTRL;
    else if (off == OFF_CFG_LOCK) sel_o = SEL_CFG_LOCK;
    else if (off == OFF_TX_LOCK)  sel_o = SEL_TX_LOCK;
    else if (off >= OFF_PAD_BASE && off[1:0] == 2'b00 &&
             {18'b0, pad_num} < NUM_PADS)
      sel_o = SEL_PAD;
  end
endmodule

// File: rtl/gpl_lock_reg.sv
module gpl_lock_reg
  import gpl_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic         priv_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] lock_o,
  output logic         clr_denied_o
);
  logic [W-1:0]  lock_q;
  logic [31:0]   cur_ext, wd_ext, nxt_ext;

  always_comb begin
    cur_ext = '0;
    wd_ext  = '0;
    cur_ext[W-1:0] = lock_q;
    wd_ext[W-1:0]  = wdata_i;
    nxt_ext        = lock_next(cur_ext, wd_ext, priv_i);
    clr_denied_o   = wr_en_i && lock_clear_denied(cur_ext, wd_ext, priv_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= '0;
    else if (wr_en_i) lock_q <= nxt_ext[W-1:0];
  end

  assign lock_o = lock_q;

  AST_LOCK_NO_UNPRIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_i |=> ((lock_q & $past(lock_q)) == $past(lock_q))); // R5
  AST_LOCK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(lock_q)); // R5
endmodule

// File: rtl/gpl_pad_cfg.sv
module gpl_pad_cfg
  import gpl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             cfg_lock_i,
  input  logic             tx_lock_i,
  input  logic             native_out_i,
  input  logic             native_oe_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             pad_out_o,
  output logic             pad_oe_o,
  output logic             blocked_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_blocked, tx_blocked;

  assign cfg_blocked = wr_en_i && cfg_lock_i;
  assign tx_blocked  = wr_en_i && !cfg_lock_i && tx_lock_i &&
                       (wdata_i[FLD_OUT] != cfg_q[FLD_OUT]);
  assign blocked_o   = cfg_blocked || tx_blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en_i && !cfg_lock_i) begin
      cfg_q[FLD_MODE] <= wdata_i[FLD_MODE];
      cfg_q[FLD_DIR]  <= wdata_i[FLD_DIR];
      if (!tx_lock_i) cfg_q[FLD_OUT] <= wdata_i[FLD_OUT];
    end
  end

  assign cfg_o     = cfg_q;
  assign pad_out_o = cfg_q[FLD_MODE] ? cfg_q[FLD_OUT] : native_out_i;
  assign pad_oe_o  = cfg_q[FLD_MODE] ? cfg_q[FLD_DIR] : native_oe_i;

  AST_CFG_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock_i |=> $stable(cfg_q)); // R3
  AST_TX_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lock_i |=> $stable(cfg_q[FLD_OUT])); // R4
endmodule

// File: rtl/gpl_bank.sv
module gpl_bank
  import gpl_pkg::*;
#(
  parameter int unsigned NUM_PADS = 24,
  parameter int unsigned ADDR_W   = 40,
  parameter logic [ADDR_W-1:0] BASE = 40'h40_0000_0000,
  parameter logic [7:0]  PORT_ID  = 8'h3A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                priv_i,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [31:0]         req_wdata_i,
  output logic                rsp_valid_o,
  output logic                rsp_hit_o,
  output logic [31:0]         rsp_rdata_o,
  input  logic [NUM_PADS-1:0] native_out_i,
  input  logic [NUM_PADS-1:0] native_oe_i,
  output logic [NUM_PADS-1:0] pad_out_o,
  output logic [NUM_PADS-1:0] pad_oe_o,
  output logic                smi_o
);
  localparam int unsigned IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

  logic             port_hit;
  sel_e             sel;
  logic [IDX_W-1:0] pad_idx;
  logic             acc, wr;
  logic             wr_ctrl, wr_cfg_lock, wr_tx_lock;

  gpl_addr_dec #(
    .ADDR_W(ADDR_W), .BASE(BASE), .PORT_ID(PORT_ID),
    .NUM_PADS(NUM_PADS), .IDX_W(IDX_W)
  ) dec_i (
    .addr_i(req_addr_i), .port_hit_o(port_hit), .sel_o(sel), .pad_idx_o(pad_idx)
  );

  assign acc         = req_valid_i && port_hit;
  assign wr          = acc && req_write_i;
  assign wr_ctrl     = wr && (sel == SEL_CTRL);
  assign wr_cfg_lock = wr && (sel == SEL_CFG_LOCK);
  assign wr_tx_lock  = wr && (sel == SEL_TX_LOCK);

  // Bank-wide lockdown, per-pad configuration locks, per-pad transmit locks
  logic [0:0]          glock;
  logic [NUM_PADS-1:0] cfg_lock, tx_lock;
  logic                glock_denied, cfg_denied, tx_denied;

  gpl_lock_reg #(.W(1)) glock_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_ctrl), .priv_i(priv_i),
    .wdata_i(req_wdata_i[CTRL_GLOCK]), .lock_o(glock), .clr_denied_o(glock_denied)
  );
  gpl_lock_reg #(.W(NUM_PADS)) cfg_lock_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_cfg_lock), .priv_i(priv_i),
    .wdata_i(req_wdata_i[NUM_PADS-1:0]), .lock_o(cfg_lock), .clr_denied_o(cfg_denied)
  );
  gpl_lock_reg #(.W(NUM_PADS)) tx_lock_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_tx_lock), .priv_i(priv_i),
    .wdata_i(req_wdata_i[NUM_PADS-1:0]), .lock_o(tx_lock), .clr_denied_o(tx_denied)
  );

  // Pads
  logic [CFG_W-1:0]        pad_cfg [NUM_PADS];
  logic [NUM_PADS-1:0]     pad_blocked;
  logic [CFG_W*NUM_PADS-1:0] cfg_flat;

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    logic pad_wr;
    assign pad_wr = wr && (sel == SEL_PAD) && (pad_idx == IDX_W'(i));
    gpl_pad_cfg pad_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(pad_wr),
      .wdata_i(req_wdata_i[CFG_W-1:0]),
      .cfg_lock_i(glock[0] || cfg_lock[i]), .tx_lock_i(tx_lock[i]),
      .native_out_i(native_out_i[i]), .native_oe_i(native_oe_i[i]),
      .cfg_o(pad_cfg[i]), .pad_out_o(pad_out_o[i]), .pad_oe_o(pad_oe_o[i]),
      .blocked_o(pad_blocked[i])
    );
    assign cfg_flat[i*CFG_W +: CFG_W] = pad_cfg[i];
  end

  // Sticky error and release interrupt
  logic any_blocked, err_q, smi_q, glock_release;

  assign any_blocked   = (|pad_blocked) || glock_denied || cfg_denied || tx_denied;
  assign glock_release = wr_ctrl && priv_i && glock[0] && !req_wdata_i[CTRL_GLOCK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      smi_q <= 1'b0;
    end else begin
      if (any_blocked)                          err_q <= 1'b1;
      else if (wr_ctrl && req_wdata_i[CTRL_ERR]) err_q <= 1'b0;
      smi_q <= glock_release;
    end
  end
  assign smi_o = smi_q;

  // Read path and response
  logic [31:0] rd_comb;
  always_comb begin
    rd_comb = '0;
    case (sel)
      SEL_CTRL: begin
        rd_comb[CTRL_GLOCK] = glock[0];
        rd_comb[CTRL_ERR]   = err_q;
      end
      SEL_CFG_LOCK: rd_comb[NUM_PADS-1:0] = cfg_lock;
      SEL_TX_LOCK:  rd_comb[NUM_PADS-1:0] = tx_lock;
      SEL_PAD:      rd_comb[CFG_W-1:0]    = pad_cfg[pad_idx];
      default:      rd_comb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= acc;
      rsp_rdata_o <= (acc && !req_write_i) ? rd_comb : 32'h0;
    end
  end

  AST_GLOCK_FREEZES_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    glock[0] |=> $stable(cfg_flat)); // R6
  AST_SMI_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glock[0]) |-> smi_q); // R7
  AST_SMI_ONLY_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_q |-> $fell(glock[0])); // R7
  AST_SMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_q |=> !smi_q); // R7
  AST_MISS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !port_hit) |=> (!rsp_hit_o && rsp_rdata_o == 32'h0)); // R8
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o); // R10
endmodule

// File: tb/gpl_bank_tb.sv
module gpl_bank_tb_top;
  localparam int unsigned NP  = 24;
  localparam int unsigned AW  = 40;
  localparam logic [AW-1:0] BASE_A = 40'h40_0000_0000;
  localparam logic [7:0]    PID    = 8'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic priv = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic rsp_valid, rsp_hit, smi;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] native_out = '0, native_oe = '0, pad_out, pad_oe;

  int checks = 0, errors = 0;
  logic        last_valid, last_hit, last_smi;
  logic [31:0] last_data;

  always #10 clk = ~clk; // 50 MHz

  gpl_bank #(.NUM_PADS(NP), .ADDR_W(AW), .BASE(BASE_A), .PORT_ID(PID)) dut_i (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .req_valid_i(req_valid),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_rdata_o(rsp_rdata),
    .native_out_i(native_out), .native_oe_i(native_oe),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .smi_o(smi)
  );

  function automatic logic [AW-1:0] mk_addr(logic [7:0] port, logic [15:0] off);
    return BASE_A + ({{(AW-8){1'b0}}, port} << 16) + {{(AW-16){1'b0}}, off};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Issue one request at a falling edge; capture the response one cycle later.
  task automatic access(input logic w, input logic p, input logic [7:0] port,
                        input logic [15:0] off, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; priv = p;
    req_addr = mk_addr(port, off); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; priv = 1'b0;
    last_valid = rsp_valid; last_hit = rsp_hit;
    last_data = rsp_rdata; last_smi = smi;
  endtask

  // {write, priv, offset, data, expected read, tag}
  typedef struct packed {
    logic        w;
    logic        p;
    logic [15:0] off;
    logic [31:0] d;
    logic [31:0] exp;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 16'h134, 32'h7,        32'h0,        "R2"},
    '{1'b0, 1'b0, 16'h134, 32'h0,        32'h7,        "R2"},
    '{1'b1, 1'b0, 16'h010, 32'h2000,     32'h0,        "R5"},
    '{1'b0, 1'b0, 16'h010, 32'h0,        32'h2000,     "R5"},
    '{1'b1, 1'b0, 16'h134, 32'h0,        32'h0,        "R3"},
    '{1'b0, 1'b0, 16'h134, 32'h0,        32'h7,        "R3"},
    '{1'b1, 1'b0, 16'h010, 32'h0,        32'h0,        "R5"},
    '{1'b0, 1'b0, 16'h010, 32'h0,        32'h2000,     "R5"},
    '{1'b1, 1'b1, 16'h010, 32'h0,        32'h0,        "R5"},
    '{1'b0, 1'b0, 16'h010, 32'h0,        32'h0,        "R5"},
    '{1'b1, 1'b0, 16'h014, 32'h2000,     32'h0,        "R4"},
    '{1'b1, 1'b0, 16'h134, 32'h2,        32'h0,        "R4"},
    '{1'b0, 1'b0, 16'h134, 32'h0,        32'h6,        "R4"},
    '{1'b1, 1'b0, 16'h000, 32'h1,        32'h0,        "R6"},
    '{1'b1, 1'b0, 16'h120, 32'h7,        32'h0,        "R6"},
    '{1'b0, 1'b0, 16'h120, 32'h0,        32'h0,        "R6"},
    '{1'b0, 1'b0, 16'h000, 32'h0,        32'h3,        "R9"},
    '{1'b1, 1'b0, 16'h000, 32'h3,        32'h0,        "R9"},
    '{1'b0, 1'b0, 16'h000, 32'h0,        32'h1,        "R9"},
    '{1'b1, 1'b1, 16'h000, 32'h0,        32'h0,        "R6"},
    '{1'b0, 1'b0, 16'h000, 32'h0,        32'h0,        "R6"},
    '{1'b1, 1'b0, 16'h120, 32'h7,        32'h0,        "R6"},
    '{1'b0, 1'b0, 16'h120, 32'h0,        32'h7,        "R6"},
    '{1'b1, 1'b1, 16'h014, 32'hFFFFFFFF, 32'h0,        "R5"},
    '{1'b0, 1'b0, 16'h014, 32'h0,        32'h00FFFFFF, "R5"},
    '{1'b0, 1'b0, 16'h178, 32'h0,        32'h0,        "R8"}
  };

  initial begin
    native_out = 24'hA5A5A5;
    native_oe  = 24'h0F0F0F;
    repeat (3) @(negedge clk);
    chk("R1 pad_out", {8'h0, pad_out}, {8'h0, native_out});
    chk("R1 pad_oe",  {8'h0, pad_oe},  {8'h0, native_oe});
    chk("R1 smi", {31'h0, smi}, 32'h0);
    rst_n = 1'b1;
    access(1'b0, 1'b0, PID, 16'h000, 32'h0); chk("R1 ctrl", last_data, 32'h0);
    access(1'b0, 1'b0, PID, 16'h010, 32'h0); chk("R1 cfg lock", last_data, 32'h0);
    access(1'b0, 1'b0, PID, 16'h014, 32'h0); chk("R1 tx lock", last_data, 32'h0);
    access(1'b0, 1'b0, PID, 16'h134, 32'h0); chk("R1 pad13", last_data, 32'h0);
    chk("R10 rsp_valid", {31'h0, last_valid}, 32'h1);

    for (int k = 0; k < NV; k++) begin
      access(VEC[k].w, VEC[k].p, PID, VEC[k].off, VEC[k].d);
      if (!VEC[k].w) chk($sformatf("%s vec%0d", VEC[k].tag, k), last_data, VEC[k].exp);
    end

    // R7: release pulse lands in the first cycle the lockdown reads 0
    access(1'b1, 1'b0, PID, 16'h000, 32'h1);
    chk("R7 no pulse on set", {31'h0, last_smi}, 32'h0);
    access(1'b1, 1'b0, PID, 16'h000, 32'h0);
    chk("R7 no pulse on unpriv", {31'h0, last_smi}, 32'h0);
    access(1'b1, 1'b1, PID, 16'h000, 32'h2);
    chk("R7 pulse", {31'h0, last_smi}, 32'h1);
    @(negedge clk);
    chk("R7 pulse width", {31'h0, smi}, 32'h0);

    // R2: output selection in software and native mode
    access(1'b1, 1'b1, PID, 16'h014, 32'h0);
    native_out[13] = 1'b0; native_oe[13] = 1'b0;
    access(1'b1, 1'b0, PID, 16'h134, 32'h7);
    chk("R2 sw out", {31'h0, pad_out[13]}, 32'h1);
    chk("R2 sw oe",  {31'h0, pad_oe[13]},  32'h1);
    access(1'b1, 1'b0, PID, 16'h134, 32'h6);
    chk("R2 native out", {31'h0, pad_out[13]}, 32'h0);
    chk("R2 native oe",  {31'h0, pad_oe[13]},  32'h0);

    // R8: wrong port ID has no effect and no hit
    access(1'b1, 1'b0, PID ^ 8'h01, 16'h134, 32'h1);
    chk("R8 miss hit", {31'h0, last_hit}, 32'h0);
    chk("R10 miss valid", {31'h0, last_valid}, 32'h1);
    access(1'b0, 1'b0, PID ^ 8'h01, 16'h134, 32'h0);
    chk("R8 miss data", last_data, 32'h0);
    access(1'b0, 1'b0, PID, 16'h134, 32'h0);
    chk("R8 unchanged", last_data, 32'h6);
    chk("R8 hit", {31'h0, last_hit}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule